// File: doc/BRIEF.md
# Interval Timer Interrupt Controller

This block turns terminal-count events from three interval timers into one interrupt request for the processor. It also holds the interrupt enables and a bus-snoop enable in one 8-bit system control register. Each timer has its own request latch. A one-cycle terminal-count pulse from that timer sets the latch, and the latch holds until software acknowledges it. Software acknowledges a timer by writing a two-bit clear code into the same register. The code names the one timer whose latch is to be cleared.

The register also gates a separate tick-timer request and drives the snoop-enable line for the cache logic. Both interrupt outputs are registered. Each latch is a two-state machine:
- LAT_IDLE: no request is pending.
- LAT_PEND: a request is pending.

Transitions:
- SET moves LAT_IDLE to LAT_PEND on a terminal-count pulse.
- ACK moves LAT_PEND to LAT_IDLE on a matching clear code with no pulse in the same cycle.
- HOLD keeps LAT_PEND when a pulse and a clear arrive together.
- STAY keeps LAT_IDLE otherwise.

Top module: `tmr_irq_ctl`

## Requirements
- R1: A terminal-count pulse on `tc_pulse[i]` sets latch i on the next clock edge. The latch stays set until it is cleared.
- R2: When bit 5 is 1, `itmr_irq` equals the OR of the three latches, delayed by one clock.
- R3: A write with `wr_data[4:3]` = 1 clears latch 0, = 2 clears latch 1 and = 3 clears latch 2. A value of 0 clears nothing. The other latches are never touched.
- R4: `rd_data[4:0]` always reads as zero. Writes to bits 2:0 have no effect.
- R5: Bit 5 enables the interval-timer interrupt. It is 0 after reset, and while it is 0, `itmr_irq` is 0.
- R6: Bit 6 enables the tick-timer interrupt. It is 1 after reset. `tick_irq` is `tick_req` AND bit 6, registered one clock later.
- R7: Bit 7 is a read/write snoop enable. It is 0 after reset and drives `snoop_en` directly.
- R8: If a terminal-count pulse and a clear for the same latch arrive in the same cycle, the latch stays set.
- R9: Local reset clears all three latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Local reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: bit 7 snoop, bit 6 tick enable, bit 5 interval enable, bits 4:3 clear code |
| rd_data | output | 8 | Register read value |
| tc_pulse | input | 3 | Terminal-count pulses, one per timer |
| tick_req | input | 1 | Tick-timer request |
| itmr_irq | output | 1 | Combined interval-timer interrupt |
| tick_irq | output | 1 | Masked tick-timer interrupt |
| snoop_en | output | 1 | Bus-snoop enable |

## Verification
A terminal-count pulse for a timer and the clear code for that same timer can land in the same clock cycle. The bench provokes this by holding `tc_pulse[0]` high while it writes clear code 1 on the same edge. It judges the result at the port: `itmr_irq` must stay at 1 on the following cycle. A clear written alone afterwards must then drop `itmr_irq` one clock later.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int REG_W     = 8;
    localparam int CLR_LSB   = 3;
    localparam int CLR_W     = 2;
    localparam int BIT_ITEN  = 5;
    localparam int BIT_TKEN  = 6;
    localparam int BIT_SNOOP = 7;

    typedef enum logic {
        LAT_IDLE = 1'b0,
        LAT_PEND = 1'b1
    } lat_state_e;
endpackage

// File: rtl/tmr_req_latch.sv
module tmr_req_latch
    import tmr_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    lat_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LAT_IDLE;
        else        state_q <= state_d;
    end

    // Next-state and output logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAT_IDLE: if (set_i) state_d = LAT_PEND;                // SET
            LAT_PEND: if (clr_i && !set_i) state_d = LAT_IDLE;      // ACK, else HOLD
            default:  state_d = LAT_IDLE;
        endcase
        pend_o = (state_q == LAT_PEND);
    end
endmodule

// File: rtl/tmr_clr_decode.sv
module tmr_clr_decode
    import tmr_irq_pkg::*;
#(
    parameter int NUM_TMR = 3
) (
    input  logic               wr_en,
    input  logic [CLR_W-1:0]   code,
    output logic [NUM_TMR-1:0] clr_vec
);
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
        assign clr_vec[i] = wr_en && (code == CLR_W'(i + 1));
    end
endmodule

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
    import tmr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             itmr_en,
    output logic             tick_en,
    output logic             snoop,
    output logic [REG_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            itmr_en <= 1'b0;
            tick_en <= 1'b1;
            snoop   <= 1'b0;
        end else if (wr_en) begin
            itmr_en <= wr_data[BIT_ITEN];
            tick_en <= wr_data[BIT_TKEN];
            snoop   <= wr_data[BIT_SNOOP];
        end
    end

    always_comb begin
        rd_data            = '0;
        rd_data[BIT_ITEN]  = itmr_en;
        rd_data[BIT_TKEN]  = tick_en;
        rd_data[BIT_SNOOP] = snoop;
    end
endmodule

// File: rtl/tmr_irq_out.sv
module tmr_irq_out #(
    parameter int NUM_TMR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] pend,
    input  logic               itmr_en,
    input  logic               tick_en,
    input  logic               tick_req,
    output logic               itmr_irq,
    output logic               tick_irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            itmr_irq <= 1'b0;
            tick_irq <= 1'b0;
        end else begin
            itmr_irq <= itmr_en && (|pend);
            tick_irq <= tick_en && tick_req;
        end
    end
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
    import tmr_irq_pkg::*;
#(
    parameter int NUM_TMR = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_TMR-1:0] tc_pulse,
    input  logic               tick_req,
    output logic               itmr_irq,
    output logic               tick_irq,
    output logic               snoop_en
);
    logic [NUM_TMR-1:0] clr_vec;
    logic [NUM_TMR-1:0] pend_vec;
    logic               itmr_en;
    logic               tick_en;

    tmr_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .itmr_en (itmr_en),
        .tick_en (tick_en),
        .snoop   (snoop_en),
        .rd_data (rd_data)
    );

    tmr_clr_decode #(.NUM_TMR(NUM_TMR)) u_dec (
        .wr_en   (wr_en),
        .code    (wr_data[CLR_LSB +: CLR_W]),
        .clr_vec (clr_vec)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_lat
        tmr_req_latch u_lat (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (tc_pulse[i]),
            .clr_i  (clr_vec[i]),
            .pend_o (pend_vec[i])
        );
    end

    tmr_irq_out #(.NUM_TMR(NUM_TMR)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend     (pend_vec),
        .itmr_en  (itmr_en),
        .tick_en  (tick_en),
        .tick_req (tick_req),
        .itmr_irq (itmr_irq),
        .tick_irq (tick_irq)
    );
endmodule

// File: rtl/tmr_irq_ctl_chk.sv
module tmr_irq_ctl_chk #(
    parameter int NUM_TMR = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_TMR-1:0] tc_pulse,
    input logic [NUM_TMR-1:0] pend_vec,
    input logic               itmr_en,
    input logic               tick_en,
    input logic               itmr_irq,
    input logic               tick_irq,
    input logic [7:0]         rd_data
);
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_set
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            tc_pulse[i] |=> pend_vec[i]); // R8
    end

    AST_IRQ_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (itmr_en && (|pend_vec)) |=> itmr_irq); // R2

    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !itmr_en |=> !itmr_irq); // R5

    AST_TICK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> !tick_irq); // R6

    AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4:0] == 5'b0); // R4
endmodule

bind tmr_irq_ctl tmr_irq_ctl_chk #(.NUM_TMR(NUM_TMR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tc_pulse (tc_pulse),
    .pend_vec (pend_vec),
    .itmr_en  (itmr_en),
    .tick_en  (tick_en),
    .itmr_irq (itmr_irq),
    .tick_irq (tick_irq),
    .rd_data  (rd_data)
);

// File: tb/tb_tmr_irq_ctl.sv
module tb_tmr_irq_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [2:0] tc_pulse = 3'b000;
    logic       tick_req = 1'b0;
    logic       itmr_irq, tick_irq, snoop_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic       it;
        logic       tk;
        logic       sn;
        logic [7:0] rd;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    tmr_irq_ctl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tc_pulse(tc_pulse), .tick_req(tick_req),
        .itmr_irq(itmr_irq), .tick_irq(tick_irq), .snoop_en(snoop_en)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string tag, logic it, logic tk, logic sn, logic [7:0] rd);
        exp_t e;
        e.tag = tag; e.it = it; e.tk = tk; e.sn = sn; e.rd = rd;
        sb_q.push_back(e);
        #1;
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic pulse(int idx);
        tc_pulse[idx] = 1'b1;
        cyc();
        tc_pulse = 3'b000;
        cyc();
    endtask

    // Monitor: pop expected items and compare against the outputs
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            begin
                exp_t e;
                logic [10:0] act, exp;
                e = sb_q.pop_front();
                act = {itmr_irq, tick_irq, snoop_en, rd_data};
                exp = {e.it, e.tk, e.sn, e.rd};
                checks++;
                if (act !== exp) begin
                    failures++;
                    $display("FAIL %s: actual it=%b tk=%b sn=%b rd=%h expected it=%b tk=%b sn=%b rd=%h",
                             e.tag, itmr_irq, tick_irq, snoop_en, rd_data, e.it, e.tk, e.sn, e.rd);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cyc();
        expect_out("R5 R6 R7 reset values", 0, 0, 0, 8'h40);

        // R6 tick path and mask
        tick_req = 1'b1;
        cyc();
        expect_out("R6 tick passes when enabled", 0, 1, 0, 8'h40);
        wr(8'h00);
        cyc();
        expect_out("R6 tick masked", 0, 0, 0, 8'h00);
        tick_req = 1'b0;
        wr(8'h40);

        // R5 mask while enable is 0, R1 latch holds
        pulse(0);
        cyc();
        expect_out("R5 masked interval request", 0, 0, 0, 8'h40);
        wr(8'h60);
        cyc();
        expect_out("R1 R2 latch held then enabled", 1, 0, 0, 8'h60);

        // R3 codes: 2 and 0 leave latch 0, 1 clears it
        wr(8'h70); cyc();
        expect_out("R3 code 2 leaves timer 0", 1, 0, 0, 8'h60);
        wr(8'h60); cyc();
        expect_out("R3 code 0 no action", 1, 0, 0, 8'h60);
        wr(8'h68); cyc();
        expect_out("R3 code 1 clears timer 0", 0, 0, 0, 8'h60);

        pulse(2);
        expect_out("R1 R2 timer 2 request", 1, 0, 0, 8'h60);
        wr(8'h70); cyc();
        expect_out("R3 code 2 leaves timer 2", 1, 0, 0, 8'h60);
        wr(8'h78); cyc();
        expect_out("R3 code 3 clears timer 2", 0, 0, 0, 8'h60);

        pulse(1);
        expect_out("R1 R2 timer 1 request", 1, 0, 0, 8'h60);
        wr(8'h70); cyc();
        expect_out("R3 code 2 clears timer 1", 0, 0, 0, 8'h60);

        // R8 set and clear in the same cycle
        pulse(0);
        expect_out("R8 pre-set", 1, 0, 0, 8'h60);
        tc_pulse[0] = 1'b1;
        wr_en = 1'b1;
        wr_data = 8'h68;
        cyc();
        tc_pulse = 3'b000;
        wr_en = 1'b0;
        cyc();
        expect_out("R8 set wins over clear", 1, 0, 0, 8'h60);
        wr(8'h68); cyc();
        expect_out("R8 later clear alone", 0, 0, 0, 8'h60);

        // R4, R7 read-back and snoop
        wr(8'hFF);
        expect_out("R4 R7 low bits read zero, snoop on", 0, 0, 1, 8'hE0);
        wr(8'h47);
        expect_out("R4 R7 snoop off, low bits ignored", 0, 0, 0, 8'h40);

        // R9 local reset clears latches
        wr(8'h60);
        pulse(1);
        expect_out("R9 request before reset", 1, 0, 0, 8'h60);
        rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        expect_out("R9 reset values again", 0, 0, 0, 8'h40);
        wr(8'h60);
        cyc();
        expect_out("R9 latches cleared by reset", 0, 0, 0, 8'h60);

        wait (sb_q.size() == 0);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule